// File: doc/BRIEF.md
# Two-Wire Register Slave with Supply Lockout

This block is a slave on a two-wire serial bus (SCL clock, SDA data, both idling high). A bus master addresses it with a fixed 7-bit device address, sends a sub-address byte to select one of a small set of 8-bit registers, and either sends a data byte to store there or issues a repeated START and reads the selected register back. Both bus inputs pass through a glitch filter, which works from a system clock that is much faster than the bus. SDA is driven open-drain: the block only ever pulls the line low.

The register contents are brought out in parallel. Two fields have a fixed meaning: the LED current code and a flag that doubles the full-scale LED current. An undervoltage-lockout input returns the bus state machine to idle and clears every register to its default value of zero.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, `led_code` is 0, `led_2x` is 0 and `sda_oe` is 0 (SDA released).
- R2: The device address is 7'b0100100 (0x24). A write frame is START, address with R/W=0, sub-address byte, data byte, STOP. The slave acknowledges the address, the sub-address and the data byte by holding SDA low through the ninth SCL clock of each byte. SDA changes only after an SCL falling edge.
- R3: Bytes go MSB first in both directions. The first bit clocked in after START is address bit 6.
- R4: A read is a sub-address write, then a repeated START, then the address with R/W=1 (ACKed). After that the slave shifts out the selected register MSB first. If the master leaves SDA high on the ninth clock (NACK), the read ends and SDA stays released.
- R5: When the address does not match, the slave gives no ACK. It ignores all further bytes until the next START and writes nothing.
- R6: A data byte is stored only at the falling SCL edge that ends its ACK clock. A frame that is cut short by STOP inside the data byte leaves the register unchanged.
- R7: `led_code` always equals register 8, and `led_2x` always equals bit 3 of register 7.
- R8: A new SCL or SDA level is accepted only after the raw input has held it for FILT_LEN consecutive system clocks (default 4). A pulse of 2 clocks on SCL while it is low, or on SDA while SCL is high, has no effect.
- R9: While `uvlo` is high, the state machine returns to idle, SDA is released and every register returns to 0x00. A frame that was in flight gets no further ACKs.
- R10: A sub-address at or above NREG (16) is ACKed. Writes to it are discarded, and reads from it return 0x00.
- R11: `regs_o[8*i+7:8*i]` equals register i for every i below NREG.
- R12: A repeated START restarts address matching. A non-matching address after a repeated START gets no ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Supply undervoltage lockout; clears port and registers |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| led_code | output | 8 | LED current code (register 8) |
| led_2x | output | 1 | Full-scale doubling flag (register 7 bit 3) |
| regs_o | output | NREG*8 | All registers, register i at bits 8i+7..8i |

## Verification
The bench puts a deliberate SDA spike inside a high data bit and an extra short SCL pulse before a byte. A filter that is too short would either count an extra clock, so the stored byte would be shifted, or see a false START and drop the write. Other frames are cut off inside the data byte, or carry a wrong address straight after START or after a repeated START. A slave that writes too early, or that does not restart matching, would change `led_code` or ACK a frame it should ignore. Lockout is raised in the middle of a frame, so a port that only cleared its registers would go on ACKing the data byte that follows. Reads of out-of-range sub-addresses and a NACK-terminated read show whether the slave returns zero and releases SDA.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h24,
  parameter int FILT_LEN = 4,
  parameter int NREG     = 16,
  parameter int LED_REG  = 8,
  parameter int CFG_REG  = 7,
  parameter int DBL_BIT  = 3
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uvlo,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  output logic [7:0]      led_code,
  output logic            led_2x,
  output logic [NREG*8-1:0] regs_o
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int AW = $clog2(NREG);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;

  logic [1:0]    raw_q, filt, filt_d;
  logic [FW-1:0] fcnt [2];
  wire  [1:0]    raw = {scl_in, sda_in};

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_filt
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          raw_q[gi] <= 1'b1;
          filt[gi]  <= 1'b1;
          fcnt[gi]  <= '0;
        end else begin
          raw_q[gi] <= raw[gi];
          if (raw_q[gi] == filt[gi])
            fcnt[gi] <= '0;
          else if (fcnt[gi] == FW'(FILT_LEN - 1)) begin
            filt[gi] <= raw_q[gi];
            fcnt[gi] <= '0;
          end else
            fcnt[gi] <= fcnt[gi] + 1'b1;
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) filt_d <= 2'b11;
    else        filt_d <= filt;

  wire scl_f = filt[1], sda_f = filt[0];
  wire scl_d = filt_d[1], sda_d = filt_d[0];
  wire start_c = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c  = scl_f & scl_d & ~sda_d & sda_f;
  wire rise    = scl_f & ~scl_d;
  wire fall    = ~scl_f & scl_d;

  st_t        st;
  logic [3:0] bitc;
  logic [7:0] sh, tx, ptr;
  logic       rw, mnack;
  logic [7:0] rf [NREG];

  wire        ptr_ok  = int'(ptr) < NREG;
  wire [7:0]  rd_byte = ptr_ok ? rf[ptr[AW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitc <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; mnack <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (uvlo) begin
      st <= S_IDLE; bitc <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; mnack <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (start_c) begin
      st   <= S_ADDR;
      bitc <= '0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else begin
      if (rise && bitc < 4'd8 && (st == S_ADDR || st == S_SUB || st == S_WDAT)) begin
        sh   <= {sh[6:0], sda_f};
        bitc <= bitc + 1'b1;
      end
      if (rise && st == S_RACK) mnack <= sda_f;
      if (fall)
        case (st)
          S_ADDR: if (bitc == 4'd8) begin
                    if (sh[7:1] == DEV_ADDR) begin
                      st <= S_AACK;
                      rw <= sh[0];
                    end else st <= S_IDLE;
                  end
          S_AACK: begin
                    bitc <= '0;
                    if (rw) begin st <= S_RDAT; tx <= rd_byte; end
                    else st <= S_SUB;
                  end
          S_SUB:  if (bitc == 4'd8) begin ptr <= sh; st <= S_SACK; end
          S_SACK: begin bitc <= '0; st <= S_WDAT; end
          S_WDAT: if (bitc == 4'd8) st <= S_WACK;
          S_WACK: begin
                    if (ptr_ok) rf[ptr[AW-1:0]] <= sh;
                    st <= S_IDLE;
                  end
          S_RDAT: if (bitc == 4'd7) st <= S_RACK;
                  else begin tx <= {tx[6:0], 1'b0}; bitc <= bitc + 1'b1; end
          S_RACK: if (mnack) st <= S_IDLE;
                  else begin st <= S_RDAT; tx <= rd_byte; bitc <= '0; end
          default: ;
        endcase
    end

  assign sda_oe   = (st == S_AACK) || (st == S_SACK) || (st == S_WACK) ||
                    (st == S_RDAT && !tx[7]);
  assign led_code = rf[LED_REG];
  assign led_2x   = rf[CFG_REG][DBL_BIT];

  generate
    for (gi = 0; gi < NREG; gi++) begin : g_out
      assign regs_o[gi*8 +: 8] = rf[gi];
    end
  endgenerate

  // R9
  uvlo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (st == S_IDLE && !sda_oe && regs_o == '0));

  // R6
  reg_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> ($past(st) == S_WACK || $past(uvlo)));

  // R5
  addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && fall && bitc == 4'd8 && sh[7:1] != DEV_ADDR && !uvlo)
      |=> !sda_oe);

  // R2
  sda_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(fall));

  // R3
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitc <= 4'd8);
endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 10;
  localparam int NREG  = 16;
  localparam logic [6:0] ADR = 7'h24;

  logic clk = 0, rst_n = 0, uvlo = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, led_2x;
  logic [7:0] led_code;
  logic [NREG*8-1:0] regs_o;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave #(.DEV_ADDR(ADR), .FILT_LEN(4), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .led_code(led_code), .led_2x(led_2x), .regs_o(regs_o));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] exp_v[$];
  string      exp_t[$];
  logic [7:0] got_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (exp_v.size() > 0 && got_q.size() > 0) begin
      logic [7:0] e, g;
      string t;
      e = exp_v.pop_front(); t = exp_t.pop_front(); g = got_q.pop_front();
      check(t, {24'd0, g}, {24'd0, e});
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic b_start();  sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic b_rstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic b_stop();   sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq();
      if (glitch && i == 7) begin
        sda_m = 0; repeat (2) @(negedge clk); sda_m = 1;
      end
      wq(); scl_m = 0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, input bit glitch = 0);
    send_bits(b, 8, glitch);
    sda_m = 1; wq(); scl_m = 1; wq(); ack = (sda_bus == 1'b0); wq(); scl_m = 0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1; wq(); b[i] = sda_bus; wq(); scl_m = 0; wq();
    end
    sda_m = nack; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); sda_m = 1;
  endtask

  task automatic wr(input logic [7:0] sub, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(sub, a1); send_byte(d, a2); b_stop();
    check({req, " ack"}, {29'd0, a0, a1, a2}, 32'd7);
  endtask

  task automatic rd(input logic [7:0] sub, input logic [7:0] e, input string req);
    bit a0, a1, a2;
    logic [7:0] g;
    exp_v.push_back(e); exp_t.push_back(req);
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(sub, a1);
    b_rstart(); send_byte({ADR, 1'b1}, a2); recv_byte(g, 1'b1); b_stop();
    got_q.push_back(g);
    check("R4 read acks", {29'd0, a0, a1, a2}, 32'd7);
    check("R4 released after NACK", {31'd0, sda_oe}, 32'd0);
  endtask

  initial begin
    bit a0, a1, a2;
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    check("R1 led_code", {24'd0, led_code}, 32'd0);
    check("R1 led_2x", {31'd0, led_2x}, 32'd0);
    check("R1 sda", {31'd0, sda_oe}, 32'd0);
    check("R1 regs", {31'd0, regs_o == '0}, 32'd1);

    wr(8'd8, 8'h64, "R2");
    check("R3 R7 led_code", {24'd0, led_code}, 32'h64);
    wr(8'd7, 8'h08, "R2");
    check("R7 led_2x", {31'd0, led_2x}, 32'd1);
    rd(8'd8, 8'h64, "R4 read reg8");
    rd(8'd7, 8'h08, "R4 read reg7");

    wr(8'd3, 8'hC3, "R11");
    check("R11 regs_o reg3", {24'd0, regs_o[31:24]}, 32'hC3);
    wr(8'd20, 8'h77, "R10");
    rd(8'd20, 8'h00, "R10 out of range read");
    rd(8'd3, 8'hC3, "R11 read reg3");

    // R5 wrong address
    b_start(); send_byte({7'h25, 1'b0}, a0); send_byte(8'd8, a1); send_byte(8'hAA, a2); b_stop();
    check("R5 no ack", {29'd0, a0, a1, a2}, 32'd0);
    check("R5 no write", {24'd0, led_code}, 32'h64);

    // R12 repeated start with wrong address
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(8'd8, a1);
    b_rstart(); send_byte({7'h25, 1'b1}, a2); b_stop();
    check("R12 acks", {29'd0, a0, a1, a2}, 32'd6);
    check("R12 released", {31'd0, sda_oe}, 32'd0);

    // R6 abort inside data byte
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(8'd8, a1);
    send_bits(8'hFF, 4, 0); b_stop();
    check("R6 aborted write", {24'd0, led_code}, 32'h64);

    // R8 glitches on SCL and SDA
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(8'd8, a1);
    scl_m = 1; repeat (2) @(negedge clk); scl_m = 0; wq();
    send_byte(8'hBC, a2, 1'b1); b_stop();
    check("R8 acks", {29'd0, a0, a1, a2}, 32'd7);
    check("R8 filtered write", {24'd0, led_code}, 32'hBC);

    // R9 lockout
    uvlo = 1; repeat (3) @(negedge clk); uvlo = 0; repeat (3) @(negedge clk);
    check("R9 led_code", {24'd0, led_code}, 32'd0);
    check("R9 led_2x", {31'd0, led_2x}, 32'd0);
    check("R9 regs", {31'd0, regs_o == '0}, 32'd1);
    wr(8'd8, 8'h11, "R9 pre");
    b_start(); send_byte({ADR, 1'b0}, a0); send_byte(8'd8, a1);
    uvlo = 1; repeat (5) @(negedge clk); uvlo = 0;
    send_byte(8'h5A, a2); b_stop();
    check("R9 mid-frame no ack", {31'd0, a2}, 32'd0);
    check("R9 mid-frame cleared", {24'd0, led_code}, 32'd0);
    wr(8'd8, 8'h99, "R9 post");
    check("R9 recovers", {24'd0, led_code}, 32'h99);

    wait (exp_v.size() == 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule